// File: doc/BRIEF.md
# Hamming Sector Code Checker and Corrector

This block judges one 512-byte flash sector after it has been read. It takes two 3-byte single-error-correcting codes: the one kept in the spare area and the one computed again over the sector as it streamed in. It compares them and sorts the outcome into one of five verdicts. When the verdict is a single flipped data bit, it repairs the sector buffer in place through a byte-wide read-modify-write port. The code is computed over the data stream elsewhere, not in this block.

Each code is first spread into a 32-bit word that has the third byte split into nibbles. The two words are then XORed. The verdict depends on how many bits of that difference are set. A zero difference means the sector is clean. Twelve set bits, one bit of each parity pair, mark a correctable data error, and the upper bits of the difference give the byte and the bit to flip. A single set bit means the stored code itself is damaged. A stored code of all ones against a computed code of all zeros is the sign of a freshly erased sector. Any other difference is reported as an uncorrectable double error.

Top module: `hamming_sector_fixer`

## Requirements
- R1: Each 24-bit code input is treated as bytes b0 = bits 7:0, b1 = bits 15:8, b2 = bits 23:16, and is spread into a 32-bit word with b0 at 7:0, the low nibble of b2 at 11:8, b1 at 23:16 and the high nibble of b2 at 27:24; all other bits are zero. The syndrome is the XOR of the two spread words.
- R2: Status codes are clean = 0, corrected = 1, code-corrupted = 2, erased = 3, uncorrectable = 4. A zero syndrome gives status 0. The block does not access the buffer, and done is high in the second cycle after start is sampled.
- R3: A syndrome with exactly 12 set bits gives status 1. The byte index is syndrome bits 27:19 and the bit index is syndrome bits 18:16. The block asserts buf_rd with that address for one cycle and reads buf_rdata one cycle later while it asserts buf_wr at the same address, writing the read byte with only that bit inverted. done follows in the next cycle, four cycles after start is sampled, and fix_byte and fix_bit show the indices. For every other verdict fix_byte and fix_bit are zero.
- R4: A syndrome with exactly one set bit gives status 2 and leaves the buffer unchanged.
- R5: When the spread stored code equals 0x0FFF0FFF and the spread computed code is zero, the status is 3 and the buffer is unchanged.
- R6: Any other nonzero syndrome gives status 4 and leaves the buffer unchanged.
- R7: done is high for exactly one cycle per accepted start. status, fix_byte and fix_bit keep their values until the next done.
- R8: start is ignored while a check is in progress. A start sampled in the cycle in which done is high is accepted.
- R9: While reset is active and after it, before any start, done, buf_rd and buf_wr are low and status, fix_byte and fix_bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a check using the two codes sampled with it |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code recomputed over the sector data |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd | output | 1 | Buffer read request; data is expected on buf_rdata one cycle later |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte to write |
| buf_rdata | input | 8 | Byte returned by the buffer |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Verdict code (see R2) |
| fix_byte | output | 9 | Index of the repaired byte |
| fix_bit | output | 3 | Index of the repaired bit |

## Verification
The completion of one check and the acceptance of the next can fall in the same cycle. done from the previous sector is high while start for the following sector is sampled. The bench raises start at the very edge on which it sees done for every operation, so each sector after the first is issued back to back. It then confirms that the new verdict, its latency and the buffer contents match those of an isolated operation. A separate directed case holds start high during the read and write of a repair and checks that no extra done appears and that the buffer holds only the intended flip.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

  typedef enum logic [2:0] {
    V_CLEAN    = 3'd0,
    V_FIXED    = 3'd1,
    V_CODE_BAD = 3'd2,
    V_ERASED   = 3'd3,
    V_DOUBLE   = 3'd4
  } verdict_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EVAL = 2'd1,
    S_RD   = 2'd2,
    S_WR   = 2'd3
  } fsm_e;

endpackage

// File: rtl/hsf_widen.sv
module hsf_widen #(
  parameter int BYTE_W = 8
) (
  input  logic [3*BYTE_W-1:0] code,
  output logic [4*BYTE_W-1:0] wide
);
  localparam int HALF = BYTE_W / 2;

  always_comb begin
    wide = '0;
    wide[BYTE_W-1:0]            = code[BYTE_W-1:0];
    wide[BYTE_W+HALF-1:BYTE_W]  = code[2*BYTE_W+HALF-1:2*BYTE_W];
    wide[3*BYTE_W-1:2*BYTE_W]   = code[2*BYTE_W-1:BYTE_W];
    wide[3*BYTE_W+HALF-1:3*BYTE_W] = code[3*BYTE_W-1:2*BYTE_W+HALF];
  end
endmodule

// File: rtl/hsf_classify.sv
module hsf_classify
  import hsf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9,
  parameter int PAIRS  = 12
) (
  input  logic [4*BYTE_W-1:0]       stored_w,
  input  logic [4*BYTE_W-1:0]       calc_w,
  input  logic [4*BYTE_W-1:0]       erased_w,
  output verdict_e                  verdict,
  output logic [ADDR_W-1:0]         byte_idx,
  output logic [$clog2(BYTE_W)-1:0] bit_idx
);
  localparam int WIDE_W = 4 * BYTE_W;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int WT_W   = $clog2(WIDE_W + 1);
  localparam int IDX_LO = 2 * BYTE_W;

  logic [WIDE_W-1:0] syn;
  logic [WT_W-1:0]   weight;

  assign syn = stored_w ^ calc_w;

  always_comb begin
    weight = '0;
    for (int i = 0; i < WIDE_W; i++) begin
      weight = weight + WT_W'(syn[i]);
    end
  end

  assign bit_idx  = syn[IDX_LO +: BIT_W];
  assign byte_idx = syn[IDX_LO+BIT_W +: ADDR_W];

  always_comb begin
    if (syn == '0)                                 verdict = V_CLEAN;
    else if (weight == WT_W'(PAIRS))               verdict = V_FIXED;
    else if (weight == WT_W'(1))                   verdict = V_CODE_BAD;
    else if (stored_w == erased_w && calc_w == '0) verdict = V_ERASED;
    else                                           verdict = V_DOUBLE;
  end
endmodule

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer
  import hsf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9,
  parameter int PAIRS  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [3*BYTE_W-1:0]       stored_code,
  input  logic [3*BYTE_W-1:0]       calc_code,
  output logic [ADDR_W-1:0]         buf_addr,
  output logic                      buf_rd,
  output logic                      buf_wr,
  output logic [BYTE_W-1:0]         buf_wdata,
  input  logic [BYTE_W-1:0]         buf_rdata,
  output logic                      done,
  output logic [2:0]                status,
  output logic [ADDR_W-1:0]         fix_byte,
  output logic [$clog2(BYTE_W)-1:0] fix_bit
);
  localparam int CODE_W = 3 * BYTE_W;
  localparam int WIDE_W = 4 * BYTE_W;
  localparam int BIT_W  = $clog2(BYTE_W);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // code spreading: stored, computed and the erased reference
  logic [CODE_W-1:0] code_src [3];
  logic [WIDE_W-1:0] code_wide [3];
  assign code_src[0] = stored_code;
  assign code_src[1] = calc_code;
  assign code_src[2] = '1;

  for (genvar g = 0; g < 3; g++) begin : g_widen
    hsf_widen #(.BYTE_W(BYTE_W)) u_widen (
      .code (code_src[g]),
      .wide (code_wide[g])
    );
  end

  // state
  fsm_e              state_q, state_d;
  logic [WIDE_W-1:0] stored_q, stored_d;
  logic [WIDE_W-1:0] calc_q, calc_d;
  logic [ADDR_W-1:0] tgt_byte_q, tgt_byte_d;
  logic [BIT_W-1:0]  tgt_bit_q, tgt_bit_d;
  logic              done_q, done_d;
  verdict_e          status_q, status_d;
  logic [ADDR_W-1:0] fixb_q, fixb_d;
  logic [BIT_W-1:0]  fixbit_q, fixbit_d;

  verdict_e          verdict;
  logic [ADDR_W-1:0] cls_byte;
  logic [BIT_W-1:0]  cls_bit;

  hsf_classify #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .PAIRS(PAIRS)) u_classify (
    .stored_w (stored_q),
    .calc_w   (calc_q),
    .erased_w (code_wide[2]),
    .verdict  (verdict),
    .byte_idx (cls_byte),
    .bit_idx  (cls_bit)
  );

  // next state
  always_comb begin
    state_d    = state_q;
    stored_d   = stored_q;
    calc_d     = calc_q;
    tgt_byte_d = tgt_byte_q;
    tgt_bit_d  = tgt_bit_q;
    done_d     = 1'b0;
    status_d   = status_q;
    fixb_d     = fixb_q;
    fixbit_d   = fixbit_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          stored_d = code_wide[0];
          calc_d   = code_wide[1];
          state_d  = S_EVAL;
        end
      end
      S_EVAL: begin
        if (verdict == V_FIXED) begin
          tgt_byte_d = cls_byte;
          tgt_bit_d  = cls_bit;
          state_d    = S_RD;
        end else begin
          done_d   = 1'b1;
          status_d = verdict;
          fixb_d   = '0;
          fixbit_d = '0;
          state_d  = S_IDLE;
        end
      end
      S_RD: state_d = S_WR;
      S_WR: begin
        done_d   = 1'b1;
        status_d = V_FIXED;
        fixb_d   = tgt_byte_q;
        fixbit_d = tgt_bit_q;
        state_d  = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= S_IDLE;
      stored_q   <= '0;
      calc_q     <= '0;
      tgt_byte_q <= '0;
      tgt_bit_q  <= '0;
      done_q     <= 1'b0;
      status_q   <= V_CLEAN;
      fixb_q     <= '0;
      fixbit_q   <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      if (state_q == S_IDLE) begin
        stored_q <= stored_d;
        calc_q   <= calc_d;
      end
      if (state_q == S_EVAL) begin
        tgt_byte_q <= tgt_byte_d;
        tgt_bit_q  <= tgt_bit_d;
      end
      if (done_d) begin
        status_q <= status_d;
        fixb_q   <= fixb_d;
        fixbit_q <= fixbit_d;
      end
    end
  end

  // buffer port and outputs
  assign buf_addr  = tgt_byte_q;
  assign buf_rd    = (state_q == S_RD);
  assign buf_wr    = (state_q == S_WR);
  assign buf_wdata = buf_rdata ^ (BYTE_W'(1) << tgt_bit_q);
  assign done      = done_q;
  assign status    = status_q;
  assign fix_byte  = fixb_q;
  assign fix_bit   = fixbit_q;
endmodule

// File: rtl/hsf_checker.sv
module hsf_checker #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              buf_rd,
  input logic              buf_wr,
  input logic [BYTE_W-1:0] buf_wdata,
  input logic [BYTE_W-1:0] buf_rdata,
  input logic              done,
  input logic [2:0]        status
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |=> (buf_wr && $stable(buf_addr)));

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $past(buf_rd));

  // R3
  one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> ($countones(buf_wdata ^ buf_rdata) == 1));

  // R3
  fixed_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |=> (done && status == 3'd1));

  // R2
  no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 3'd1) |-> (!$past(buf_wr) && !$past(buf_rd)));

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd && buf_wr));
endmodule

bind hamming_sector_fixer hsf_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_addr  (buf_addr),
  .buf_rd    (buf_rd),
  .buf_wr    (buf_wr),
  .buf_wdata (buf_wdata),
  .buf_rdata (buf_rdata),
  .done      (done),
  .status    (status)
);

// File: tb/hamming_sector_fixer_test.sv
module hamming_sector_fixer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SECT = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] calc_code = '0;
  logic [8:0]  buf_addr;
  logic        buf_rd, buf_wr;
  logic [7:0]  buf_wdata;
  logic [7:0]  buf_rdata = '0;
  logic        done;
  logic [2:0]  status;
  logic [8:0]  fix_byte;
  logic [2:0]  fix_bit;

  int errors = 0;
  int checks = 0;
  logic [7:0] mem    [SECT];
  logic [7:0] shadow [SECT];

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_sector_fixer uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stored_code(stored_code), .calc_code(calc_code),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .done(done), .status(status), .fix_byte(fix_byte), .fix_bit(fix_bit)
  );

  // sector buffer model: one-cycle read latency
  always @(posedge clk) begin
    if (buf_wr) mem[buf_addr] <= buf_wdata;
    if (buf_rd) buf_rdata <= mem[buf_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] spread(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] gather(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic int expect_status(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] d;
    d = spread(s) ^ spread(c);
    if (d == 0) return 0;
    if ($countones(d) == 12) return 1;
    if ($countones(d) == 1) return 2;
    if (spread(s) == 32'h0FFF0FFF && spread(c) == 0) return 3;
    return 4;
  endfunction

  task automatic wait_done(output int lat);
    lat = 0;
    while (lat < 20) begin
      @(negedge clk);
      lat++;
      if (done) return;
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < SECT; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, req, "buffer mismatching bytes", bad, 0);
  endtask

  // issue one check, starting at a negedge, and verify its result
  task automatic run_op(input logic [23:0] s, input logic [23:0] c, input string req);
    int exp_st, lat;
    logic [31:0] d;
    logic [8:0] eb;
    logic [2:0] et;
    exp_st = expect_status(s, c);
    d  = spread(s) ^ spread(c);
    eb = (exp_st == 1) ? d[27:19] : 9'd0;
    et = (exp_st == 1) ? d[18:16] : 3'd0;
    stored_code = s;
    calc_code   = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(done === 1'b1, req, "done seen", done, 1);
    chk(status === 3'(exp_st), req, "status", status, exp_st);
    chk(lat == ((exp_st == 1) ? 3 : 1), (exp_st == 1) ? "R3" : "R2", "latency", lat,
        (exp_st == 1) ? 3 : 1);
    chk(fix_byte === eb && fix_bit === et, "R3", "fix index", {fix_byte, fix_bit}, {eb, et});
    if (exp_st == 1) shadow[eb] = shadow[eb] ^ (8'h1 << et);
    compare_mem(req);
  endtask

  function automatic logic [23:0] make_fix(input logic [23:0] s, input logic [8:0] b,
                                           input logic [2:0] t);
    logic [31:0] w;
    logic [11:0] lo;
    int need;
    need = 12 - $countones({b, t});
    lo = '0;
    while ($countones(lo) < need) lo[$urandom % 12] = 1'b1;
    w = '0;
    w[27:16] = {b, t};
    w[11:8]  = lo[11:8];
    w[7:0]   = lo[7:0];
    return s ^ gather(w);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] s;
    logic [23:0] x;
    int lat;
    void'($urandom(32'h5EC7));
    for (int i = 0; i < SECT; i++) begin
      mem[i] = 8'($urandom);
      shadow[i] = mem[i];
    end

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && buf_rd === 1'b0 && buf_wr === 1'b0, "R9", "strobes in reset",
        {done, buf_rd, buf_wr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b0 && status === 3'd0 && fix_byte === 9'd0 && fix_bit === 3'd0,
        "R9", "state after reset", {done, status, fix_byte, fix_bit}, 0);

    // R2: clean
    run_op(24'h3C5A96, 24'h3C5A96, "R2");
    // R1: directed repair whose byte index lives in the split nibble of b2
    s = 24'h000000;
    x = make_fix(s, 9'h1A5, 3'd6);
    run_op(s, x, "R1");
    run_op(24'h123456, make_fix(24'h123456, 9'd0, 3'd0), "R3");
    run_op(24'hABCDEF, make_fix(24'hABCDEF, 9'd511, 3'd7), "R3");
    // R4: single code bit damaged, including a nibble of b2
    run_op(24'h00FF00, 24'h01FF00, "R4");
    run_op(24'h00FF00, 24'h08FF00, "R4");
    // R5: erased and near-erased
    run_op(24'hFFFFFF, 24'h000000, "R5");
    run_op(24'hFFFFFF, 24'h000001, "R6");
    run_op(24'hFFFFFE, 24'h000000, "R6");
    // R6: weights 11 and 13 are not repairs
    run_op(24'h000000, 24'h0007FF, "R6");
    run_op(24'h000000, 24'h001FFF, "R6");

    // R8: start held during the read and write of a repair is ignored
    s = 24'h5A5A5A;
    x = make_fix(s, 9'd77, 3'd2);
    stored_code = s;
    calc_code = x;
    start = 1'b1;
    @(negedge clk);
    stored_code = 24'h111111;
    calc_code = 24'h222222;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && status === 3'd1, "R8", "repair done while start held",
        {done, status}, {1'b1, 3'd1});
    shadow[77] = shadow[77] ^ 8'h04;
    lat = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    chk(lat == 0, "R8", "extra done pulses", lat, 0);
    compare_mem("R8");

    // R7/R8: random mix, always issued back to back in the done cycle
    for (int n = 0; n < 120; n++) begin
      s = 24'($urandom);
      case ($urandom % 4)
        0: x = s;
        1: x = make_fix(s, 9'($urandom), 3'($urandom));
        2: x = s ^ (24'h1 << ($urandom % 24));
        default: begin
          x = s ^ (24'h1 << ($urandom % 24));
          x = x ^ (24'h1 << ($urandom % 24));
          if (x == s) x = s ^ 24'h000003;
        end
      endcase
      run_op(s, x, "R8");
    end
    // R7: status and index held after the pulse
    @(negedge clk);
    @(negedge clk);
    chk(done === 1'b0 && status === 3'(expect_status(s, x)), "R7", "status held",
        status, expect_status(s, x));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule